// File: doc/BRIEF.md
# SD Data FIFO Byte Packer

This block sits between a 32-bit host data register and a byte-wide card data port. A 16-word circular FIFO holds the data. During a card-to-host transfer, incoming card bytes are assembled into 32-bit words with the first byte in the low lane, and each finished word is pushed into the FIFO. During a host-to-card transfer, words are taken from the FIFO and sent to the card one byte at a time, low lane first.

A transfer starts when the host writes a block count. At that point the remaining-byte counter is loaded with block size times block count, and the direction is latched. The engine moves at most one byte per clock. The card port uses a valid/ready handshake in each direction.

The block raises sticky status bits for data movement and for block boundaries. The host clears them by writing ones. A debug word shows the transfer state code and the FIFO fill level.

Top module: `sd_fifo_packer`

## Requirements
- R1: The FIFO holds 16 words. A host push while the FIFO is full is dropped: the level stays 16 and the stored words and their order are unchanged.
- R2: `host_rdata_o` shows the oldest FIFO word, and a `host_rd_i` pulse removes it. When the FIFO is empty, `host_rdata_o` reads 0 and a pop leaves the level at 0.
- R3: A `blk_cnt_wr_i` pulse loads the remaining count with `blk_size_i * blk_cnt_i` and latches `xfer_write_i`. State codes in `dbg_o[3:0]`:
  - 0 after reset.
  - 2 while a read has bytes left.
  - 3 while a write has bytes left.
  - 1 once the remaining count is zero.
- R4: On a read, the card bytes of each word are placed at bit offsets 0, 8, 16 and 24, in arrival order. The 4th byte pushes the word.
- R5: If a read ends part-way through a word, the partial word is pushed with its unused upper bytes zero.
- R6: `card_rx_ready_o` is high only when all of these hold:
  - a read has bytes left;
  - the FIFO is not full;
  - `host_wr_i` is low.
- R7: On a write, each FIFO word is sent on `card_tx_data_o` low byte first. The remaining count drops by one per accepted byte. `card_tx_valid_o` is low once the count is zero.
- R8: Every word the engine pushes or pops sets status bit 0. It also sets status bit 8 when `cfg_data_irq_en_i` is high.
- R9: During a write, status bit 9 is set when an accepted byte leaves a remaining count that is a nonzero-size multiple of the block size, provided `cfg_blk_irq_en_i` is high.
- R10: A 1 at any bit of `stat_clr_i` clears that status bit. A clear does not affect the other bits.
- R11: `dbg_o[8:4]` always shows the FIFO fill level (0 to 16).
- R12: At most one card byte is moved per clock; `card_rx_ready_o` and `card_tx_valid_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| host_wr_i | input | 1 | Push `host_wdata_i` into the FIFO |
| host_wdata_i | input | 32 | Host data word |
| host_rd_i | input | 1 | Pop the oldest FIFO word |
| host_rdata_o | output | 32 | Oldest FIFO word, 0 when empty |
| blk_size_i | input | 10 | Block size in bytes |
| blk_cnt_i | input | 9 | Block count |
| blk_cnt_wr_i | input | 1 | Load the remaining count and start the transfer |
| xfer_write_i | input | 1 | Direction sampled at load: 1 host-to-card, 0 card-to-host |
| cfg_data_irq_en_i | input | 1 | Enable status bit 8 |
| cfg_blk_irq_en_i | input | 1 | Enable status bit 9 |
| stat_clr_i | input | 10 | Write-one-to-clear mask for status |
| status_o | output | 10 | Status: bit 0 data, bit 8 data interrupt, bit 9 block interrupt |
| dbg_o | output | 9 | [3:0] state code, [8:4] FIFO level |
| card_rx_valid_i | input | 1 | Card byte valid |
| card_rx_data_i | input | 8 | Card byte |
| card_rx_ready_o | output | 1 | Block accepts a card byte |
| card_tx_valid_o | output | 1 | Byte to card valid |
| card_tx_data_o | output | 8 | Byte to card |
| card_tx_ready_i | input | 1 | Card accepts the byte |

## Verification
Results appear on the clock edge that accepts the stimulus:
- A host push or pop changes `dbg_o[8:4]` and `host_rdata_o` on that edge.
- An accepted 4th or final read byte places its word at the FIFO head on that edge.
- Status bits and the state code update on the edge of the byte or load that caused them.
- `card_rx_ready_o` and `card_tx_valid_o` are combinational from registered state and the current host strobes.

The bench changes inputs only on falling edges. It samples results at the next falling edge. It reads the handshake outputs 1 ns after driving, inside the same low phase.

// File: rtl/sdf_pkg.sv
package sdf_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned STAT_W = 10;
  localparam int unsigned STAT_DATA = 0;
  localparam int unsigned STAT_DIRQ = 8;
  localparam int unsigned STAT_BIRQ = 9;

  typedef enum logic [3:0] {
    ST_RESET = 4'h0,
    ST_DONE  = 4'h1,
    ST_RD    = 4'h2,
    ST_WR    = 4'h3
  } xfer_state_e;
endpackage

// File: rtl/sdf_fifo.sv
module sdf_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 32,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  push_data_i,
  input  logic          pop_i,
  output logic [W-1:0]  head_o,
  output logic [CW-1:0] count_o,
  output logic          full_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] count_q;
  logic          do_push, do_pop, empty;

  assign empty   = (count_q == '0);
  assign full_o  = (count_q == CW'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty;
  assign head_o  = empty ? '0 : mem_q[rd_ptr_q];
  assign count_o = count_q;

  function automatic logic [AW-1:0] inc_ptr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (do_push) wr_ptr_q <= inc_ptr(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= inc_ptr(rd_ptr_q);
      case ({do_push, do_pop})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  // R1
  level_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CW'(DEPTH));
  // R1
  full_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i) |=> $stable(count_q));
  // R2
  empty_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty && !push_i) |=> (count_q == '0));
endmodule

// File: rtl/sdf_rx_pack.sv
module sdf_rx_pack #(
  parameter int unsigned W  = 32,
  parameter int unsigned B  = 8,
  localparam int unsigned N  = W / B,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         fire_i,
  input  logic         last_i,
  input  logic [B-1:0] byte_i,
  output logic         push_o,
  output logic [W-1:0] word_o
);
  logic [IW-1:0] idx_q;
  logic [W-1:0]  acc_q;

  assign word_o = acc_q | (W'(byte_i) << (B * idx_q));
  assign push_o = fire_i && ((idx_q == IW'(N - 1)) || last_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      acc_q <= '0;
    end else if (clear_i || push_o) begin
      idx_q <= '0;
      acc_q <= '0;
    end else if (fire_i) begin
      idx_q <= idx_q + 1'b1;
      acc_q <= word_o;
    end
  end
endmodule

// File: rtl/sdf_tx_unpack.sv
module sdf_tx_unpack #(
  parameter int unsigned W  = 32,
  parameter int unsigned B  = 8,
  localparam int unsigned N  = W / B,
  localparam int unsigned LW = $clog2(N) + 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         active_i,
  input  logic         hold_i,
  input  logic         avail_i,
  input  logic [W-1:0] head_i,
  input  logic         ready_i,
  output logic         valid_o,
  output logic [B-1:0] data_o,
  output logic         pop_o
);
  logic [LW-1:0] left_q;
  logic [W-1:0]  sh_q;
  logic          have, fire;

  assign have    = (left_q != '0);
  // a fresh word is fetched only when the host is not popping in the same cycle
  assign valid_o = active_i && (have || (avail_i && !hold_i));
  assign data_o  = have ? sh_q[B-1:0] : head_i[B-1:0];
  assign fire    = valid_o && ready_i;
  assign pop_o   = fire && !have;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q <= '0;
      sh_q   <= '0;
    end else if (clear_i) begin
      left_q <= '0;
      sh_q   <= '0;
    end else if (fire) begin
      if (have) begin
        sh_q   <= sh_q >> B;
        left_q <= left_q - 1'b1;
      end else begin
        sh_q   <= head_i >> B;
        left_q <= LW'(N - 1);
      end
    end
  end
endmodule

// File: rtl/sd_fifo_packer.sv
module sd_fifo_packer
  import sdf_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 16,
  parameter int unsigned BSIZE_W    = 10,
  parameter int unsigned BCOUNT_W   = 9,
  localparam int unsigned REM_W     = BSIZE_W + BCOUNT_W,
  localparam int unsigned LVL_W     = $clog2(FIFO_DEPTH) + 1,
  localparam int unsigned DBG_W     = 4 + LVL_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                host_wr_i,
  input  logic [WORD_W-1:0]   host_wdata_i,
  input  logic                host_rd_i,
  output logic [WORD_W-1:0]   host_rdata_o,
  input  logic [BSIZE_W-1:0]  blk_size_i,
  input  logic [BCOUNT_W-1:0] blk_cnt_i,
  input  logic                blk_cnt_wr_i,
  input  logic                xfer_write_i,
  input  logic                cfg_data_irq_en_i,
  input  logic                cfg_blk_irq_en_i,
  input  logic [STAT_W-1:0]   stat_clr_i,
  output logic [STAT_W-1:0]   status_o,
  output logic [DBG_W-1:0]    dbg_o,
  input  logic                card_rx_valid_i,
  input  logic [BYTE_W-1:0]   card_rx_data_i,
  output logic                card_rx_ready_o,
  output logic                card_tx_valid_o,
  output logic [BYTE_W-1:0]   card_tx_data_o,
  input  logic                card_tx_ready_i
);
  logic [REM_W-1:0]   rem_q, load_prod;
  logic [BSIZE_W-1:0] size_q, blk_left_q;
  logic               dir_wr_q;
  xfer_state_e        state_q;
  logic [STAT_W-1:0]  status_q, stat_set;

  logic [LVL_W-1:0]   fifo_count;
  logic               fifo_full, fifo_push, fifo_pop;
  logic [WORD_W-1:0]  fifo_head, fifo_wdata;
  logic               pk_push, up_pop;
  logic [WORD_W-1:0]  pk_word;
  logic               rx_fire, tx_fire, byte_fire, tx_active, bytes_left;

  assign bytes_left      = (rem_q != '0);
  assign card_rx_ready_o = !dir_wr_q && bytes_left && !blk_cnt_wr_i && !fifo_full && !host_wr_i;
  assign tx_active       = dir_wr_q && bytes_left && !blk_cnt_wr_i;
  assign rx_fire         = card_rx_ready_o && card_rx_valid_i;
  assign tx_fire         = card_tx_valid_o && card_tx_ready_i;
  assign byte_fire       = rx_fire || tx_fire;
  assign load_prod       = REM_W'(blk_cnt_i) * REM_W'(blk_size_i);

  // host push and engine push never coincide: a host write stalls the receive side
  assign fifo_push  = pk_push || host_wr_i;
  assign fifo_wdata = pk_push ? pk_word : host_wdata_i;
  assign fifo_pop   = up_pop || host_rd_i;

  sdf_fifo #(.DEPTH(FIFO_DEPTH), .W(WORD_W)) u_fifo (
    .clk_i, .rst_ni,
    .push_i(fifo_push), .push_data_i(fifo_wdata), .pop_i(fifo_pop),
    .head_o(fifo_head), .count_o(fifo_count), .full_o(fifo_full)
  );

  sdf_rx_pack #(.W(WORD_W), .B(BYTE_W)) u_rx_pack (
    .clk_i, .rst_ni,
    .clear_i(blk_cnt_wr_i), .fire_i(rx_fire), .last_i(rem_q == REM_W'(1)),
    .byte_i(card_rx_data_i), .push_o(pk_push), .word_o(pk_word)
  );

  sdf_tx_unpack #(.W(WORD_W), .B(BYTE_W)) u_tx_unpack (
    .clk_i, .rst_ni,
    .clear_i(blk_cnt_wr_i), .active_i(tx_active), .hold_i(host_rd_i),
    .avail_i(fifo_count != '0), .head_i(fifo_head), .ready_i(card_tx_ready_i),
    .valid_o(card_tx_valid_o), .data_o(card_tx_data_o), .pop_o(up_pop)
  );

  always_comb begin
    stat_set            = '0;
    stat_set[STAT_DATA] = pk_push || up_pop;
    stat_set[STAT_DIRQ] = (pk_push || up_pop) && cfg_data_irq_en_i;
    stat_set[STAT_BIRQ] = tx_fire && (blk_left_q == BSIZE_W'(1)) && cfg_blk_irq_en_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q      <= '0;
      size_q     <= '0;
      blk_left_q <= '0;
      dir_wr_q   <= 1'b0;
      state_q    <= ST_RESET;
      status_q   <= '0;
    end else begin
      status_q <= (status_q & ~stat_clr_i) | stat_set;
      if (blk_cnt_wr_i) begin
        rem_q      <= load_prod;
        size_q     <= blk_size_i;
        blk_left_q <= blk_size_i;
        dir_wr_q   <= xfer_write_i;
        state_q    <= (load_prod == '0) ? ST_DONE : (xfer_write_i ? ST_WR : ST_RD);
      end else if (byte_fire) begin
        rem_q <= rem_q - 1'b1;
        if (rem_q == REM_W'(1)) state_q <= ST_DONE;
        if (tx_fire) blk_left_q <= (blk_left_q == BSIZE_W'(1)) ? size_q : blk_left_q - 1'b1;
      end
    end
  end

  assign host_rdata_o = fifo_head;
  assign status_o     = status_q;
  assign dbg_o        = {fifo_count, state_q};

  // R3
  load_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_cnt_wr_i |=> rem_q == REM_W'($past(blk_cnt_i)) * REM_W'($past(blk_size_i)));
  // R7
  byte_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_fire |=> rem_q == $past(rem_q) - REM_W'(1));
  // R12
  one_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(card_rx_ready_o && card_tx_valid_o));
  // R8
  dirq_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_q[STAT_DIRQ]) |-> $past(cfg_data_irq_en_i));
  // R9
  birq_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_q[STAT_BIRQ]) |-> $past(dir_wr_q) && $past(cfg_blk_irq_en_i));
endmodule

// File: tb/sd_fifo_packer_bench.sv
module sd_fifo_packer_bench;
  logic        clk = 0, rst_ni = 0;
  logic        host_wr_i = 0, host_rd_i = 0;
  logic [31:0] host_wdata_i = 0, host_rdata_o;
  logic [9:0]  blk_size_i = 0;
  logic [8:0]  blk_cnt_i = 0;
  logic        blk_cnt_wr_i = 0, xfer_write_i = 0;
  logic        cfg_data_irq_en_i = 0, cfg_blk_irq_en_i = 0;
  logic [9:0]  stat_clr_i = 0, status_o;
  logic [8:0]  dbg_o;
  logic        card_rx_valid_i = 0, card_rx_ready_o;
  logic [7:0]  card_rx_data_i = 0;
  logic        card_tx_valid_o, card_tx_ready_i = 0;
  logic [7:0]  card_tx_data_o;
  int          n_chk = 0, n_err = 0;
  logic [7:0]  txb [16];

  always #5 clk = ~clk;

  sd_fifo_packer u_sd_fifo_packer (
    .clk_i(clk), .rst_ni, .host_wr_i, .host_wdata_i, .host_rd_i, .host_rdata_o,
    .blk_size_i, .blk_cnt_i, .blk_cnt_wr_i, .xfer_write_i,
    .cfg_data_irq_en_i, .cfg_blk_irq_en_i, .stat_clr_i, .status_o, .dbg_o,
    .card_rx_valid_i, .card_rx_data_i, .card_rx_ready_o,
    .card_tx_valid_o, .card_tx_data_o, .card_tx_ready_i
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic host_push(input logic [31:0] w);
    @(negedge clk); host_wr_i = 1; host_wdata_i = w;
    @(negedge clk); host_wr_i = 0;
  endtask

  task automatic host_pop(output logic [31:0] w);
    @(negedge clk); w = host_rdata_o; host_rd_i = 1;
    @(negedge clk); host_rd_i = 0;
  endtask

  task automatic load(input int sz, input int cnt, input logic wr);
    @(negedge clk); blk_size_i = 10'(sz); blk_cnt_i = 9'(cnt); xfer_write_i = wr; blk_cnt_wr_i = 1;
    @(negedge clk); blk_cnt_wr_i = 0;
  endtask

  task automatic clr_status(input logic [9:0] m);
    @(negedge clk); stat_clr_i = m;
    @(negedge clk); stat_clr_i = 0;
  endtask

  task automatic feed(input int n, input logic [7:0] start, input logic [7:0] step);
    int i = 0;
    while (i < n) begin
      @(negedge clk); card_rx_valid_i = 1; card_rx_data_i = 8'(start + step * i);
      #1; if (card_rx_ready_o) i++;
    end
    @(negedge clk); card_rx_valid_i = 0;
  endtask

  task automatic collect(input int n);
    int k = 0;
    @(negedge clk); card_tx_ready_i = 1;
    while (k < n) begin
      #1;
      if (card_tx_valid_o) begin txb[k] = card_tx_data_o; k++; end
      if (k < n) @(negedge clk);
    end
    @(negedge clk); card_tx_ready_i = 0;
  endtask

  task automatic t_reset;
    check("R3 reset state", 32'(dbg_o[3:0]), 0);
    check("R11 reset level", 32'(dbg_o[8:4]), 0);
    check("R10 reset status", 32'(status_o), 0);
    check("R2 reset rdata", host_rdata_o, 0);
    check("R6 reset rx_ready", 32'(card_rx_ready_o), 0);
    check("R7 reset tx_valid", 32'(card_tx_valid_o), 0);
  endtask

  task automatic t_full;
    logic [31:0] w;
    for (int i = 0; i < 17; i++) host_push(32'hA000_0000 + 32'(i));
    check("R11 level full", 32'(dbg_o[8:4]), 16);
    for (int i = 0; i < 16; i++) begin
      host_pop(w);
      check("R1 order after drop", w, 32'hA000_0000 + 32'(i));
    end
    check("R11 level empty", 32'(dbg_o[8:4]), 0);
    host_pop(w);
    check("R2 empty pop zero", w, 0);
    check("R2 empty pop level", 32'(dbg_o[8:4]), 0);
  endtask

  task automatic t_read;
    logic [31:0] w;
    cfg_data_irq_en_i = 1;
    clr_status(10'h3FF);
    load(6, 1, 0);
    check("R3 read state", 32'(dbg_o[3:0]), 2);
    feed(6, 8'h11, 8'h11);
    check("R3 read done state", 32'(dbg_o[3:0]), 1);
    check("R11 read level", 32'(dbg_o[8:4]), 2);
    check("R8 read status", 32'(status_o), 32'h101);
    check("R6 ready after end", 32'(card_rx_ready_o), 0);
    host_pop(w); check("R4 packed word", w, 32'h4433_2211);
    host_pop(w); check("R5 partial word", w, 32'h0000_6655);
  endtask

  task automatic t_read_noirq;
    logic [31:0] w;
    cfg_data_irq_en_i = 0;
    clr_status(10'h3FF);
    load(4, 1, 0);
    feed(4, 8'hA1, 8'h01);
    check("R8 data flag only", 32'(status_o), 32'h001);
    host_pop(w); check("R4 second word", w, 32'hA4A3_A2A1);
  endtask

  task automatic t_backpressure;
    logic [31:0] w;
    load(4, 17, 0);
    feed(64, 8'h00, 8'h01);
    repeat (2) @(negedge clk);
    check("R1 level at full", 32'(dbg_o[8:4]), 16);
    #1 check("R6 ready low when full", 32'(card_rx_ready_o), 0);
    host_pop(w); check("R4 first word", w, 32'h0302_0100);
    #1 check("R6 ready after pop", 32'(card_rx_ready_o), 1);
    host_wr_i = 1; #1;
    check("R6 ready low on host write", 32'(card_rx_ready_o), 0);
    host_wr_i = 0;
    feed(4, 8'h40, 8'h01);
    check("R3 done after 68", 32'(dbg_o[3:0]), 1);
    check("R11 level refilled", 32'(dbg_o[8:4]), 16);
    host_pop(w); check("R4 second slot", w, 32'h0706_0504);
    for (int i = 0; i < 14; i++) host_pop(w);
    check("R4 last word", w, 32'h3F3E_3D3C);
    host_pop(w); check("R4 final word", w, 32'h4342_4140);
  endtask

  task automatic t_write;
    cfg_data_irq_en_i = 1; cfg_blk_irq_en_i = 1;
    clr_status(10'h3FF);
    host_push(32'h4433_2211);
    host_push(32'h8877_6655);
    load(4, 2, 1);
    check("R3 write state", 32'(dbg_o[3:0]), 3);
    #1 check("R12 no rx on write", 32'(card_rx_ready_o), 0);
    collect(4);
    check("R7 byte0", 32'(txb[0]), 32'h11);
    check("R7 byte1", 32'(txb[1]), 32'h22);
    check("R7 byte3", 32'(txb[3]), 32'h44);
    check("R9 block irq", 32'(status_o), 32'h301);
    clr_status(10'h3FF);
    check("R10 cleared", 32'(status_o), 0);
    collect(4);
    check("R7 byte4", 32'(txb[0]), 32'h55);
    check("R7 byte7", 32'(txb[3]), 32'h88);
    check("R9 second block irq", 32'(status_o), 32'h301);
    check("R3 write done", 32'(dbg_o[3:0]), 1);
    check("R11 write level", 32'(dbg_o[8:4]), 0);
    #1 check("R7 valid low at end", 32'(card_tx_valid_o), 0);
  endtask

  task automatic t_write_partial;
    cfg_blk_irq_en_i = 0;
    clr_status(10'h3FF);
    host_push(32'h0403_0201);
    host_push(32'h0807_0605);
    load(6, 1, 1);
    collect(6);
    check("R7 partial byte4", 32'(txb[4]), 32'h05);
    check("R7 partial byte5", 32'(txb[5]), 32'h06);
    check("R9 no irq when disabled", 32'(status_o), 32'h101);
    #1 check("R7 stop after count", 32'(card_tx_valid_o), 0);
    check("R11 both popped", 32'(dbg_o[8:4]), 0);
  endtask

  task automatic t_w1c;
    cfg_blk_irq_en_i = 1;
    clr_status(10'h3FF);
    host_push(32'h0000_00EE);
    load(1, 1, 1);
    collect(1);
    check("R9 size one block", 32'(status_o), 32'h301);
    clr_status(10'h001);
    check("R10 partial clear", 32'(status_o), 32'h300);
    clr_status(10'h100);
    check("R10 second clear", 32'(status_o), 32'h200);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_ni = 1;
        @(negedge clk);
        t_reset();
        t_full();
        t_read();
        t_read_noirq();
        t_backpressure();
        t_write();
        t_write_partial();
        t_w1c();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule